// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block tracks the power state of a processor core and runs on the bus clock. The bus clock keeps running in every state. The machine has five states: full execution, automatic halt, stop-grant, a snoop state entered from a stopped condition, and sleep. A halt instruction or an active-low stop-clock request moves the core out of execution. The controller then issues one-cycle requests for the matching bus transaction, and it gates a core-run enable.

During stop-grant, wake events are not acted on. Each one is recorded in a sticky pending flag, which software reads and acknowledges after the core is running again. A bus snoop that begins while the core is halted or stopped takes the machine into the snoop state. When the snoop completes, the machine goes back to the exact state it left.

Leaving stop-grant is not immediate. The stop-clock release must hold for a fixed number of bus-clock periods before the core runs. A reset event during stop-grant re-initialises the core, but the core stays stopped.

Top module: `pwr_stopclk_ctrl`

## Requirements
- R1: After reset the machine is in the run state: `core_run_o`=1, `snoop_en_o`=0, `pend_o`=0, and no request pulse is active.
- R2: In the run state, `halt_i`=1 with `stpclk_n`=1 enters auto-halt one clock later. `halt_cyc_o` is high for exactly that one cycle, `core_run_o` drops to 0 and `snoop_en_o` rises to 1.
- R3: In auto-halt, any bit of `wake_ev_i` or `rst_ev_i` returns the machine to the run state one clock later.
- R4: `stpclk_n`=0 in the run state or in auto-halt enters stop-grant one clock later. `stopgnt_req_o` pulses for exactly one cycle per entry, even while `stpclk_n` stays low.
- R5: In stop-grant, the run state is reached on the EXIT_CYCLES-th consecutive clock edge at which `stpclk_n`=1 is sampled (10 by default). `core_run_o` stays 0 until then. Re-asserting stop-clock restarts the count.
- R6: In stop-grant, each `wake_ev_i` bit is latched into the same bit of `pend_o`. The bit order is 0 INIT, 1 BINIT, 2 INTR, 3 NMI, 4 SMI. A latched bit stays set after the exit until it is acknowledged.
- R7: Wake events in stop-grant do not wake the core: `core_run_o` stays 0.
- R8: `rst_ev_i` in the run state, auto-halt or stop-grant gives a one-cycle `reinit_o` pulse one clock later. In stop-grant the machine remains in stop-grant.
- R9: `snp_start_i` in stop-grant or auto-halt enters the snoop state, where `snoop_en_o`=1 and `core_run_o`=0. `snp_done_i` returns the machine to the state it came from.
- R10: In stop-grant, `slp_n`=0 while `stpclk_n`=0 enters sleep, where `snoop_en_o`=0. Snoop starts and wake events are ignored in sleep. `slp_n`=1 returns the machine to stop-grant.
- R11: `pend_ack_i`=1 clears all of `pend_o` only in the run state. In any other state it has no effect.
- R12: Stop-clock wins over a simultaneous halt in the run state. In auto-halt it wins over a simultaneous snoop start or wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stpclk_n | input | 1 | Active-low stop-clock request |
| slp_n | input | 1 | Active-low sleep request |
| halt_i | input | 1 | Halt instruction executed strobe |
| snp_start_i | input | 1 | Bus snoop phase started |
| snp_done_i | input | 1 | Snoop serviced |
| wake_ev_i | input | 5 | Wake events: 0 INIT, 1 BINIT, 2 INTR, 3 NMI, 4 SMI |
| rst_ev_i | input | 1 | Reset event |
| pend_ack_i | input | 1 | Acknowledge and clear pending flags |
| stopgnt_req_o | output | 1 | One-cycle stop-grant transaction request |
| halt_cyc_o | output | 1 | One-cycle halt bus cycle request |
| core_run_o | output | 1 | Core execution enable |
| snoop_en_o | output | 1 | Snoops accepted |
| reinit_o | output | 1 | One-cycle core re-initialise pulse |
| pend_o | output | 5 | Latched pending wake events |

## Verification
The bench first re-asserts stop-clock partway through an exit countdown and then counts the cycles to the run state. A design with a counter that does not restart, or an off-by-one count, reaches the run state early or late. Snoops are started from both stop-grant and auto-halt. A single shared return target would send an auto-halt snoop back into stop-grant, and a following wake event would then be latched instead of waking the core. Simultaneous stop-clock with a halt, a snoop start or a wake event exposes reversed priorities as a missing stop-grant pulse. Acknowledges and events in sleep and stop-grant expose pending flags that clear or set in the wrong state.

// File: rtl/pwr_stopclk_pkg.sv
package pwr_stopclk_pkg;

   typedef enum logic [2:0] {
      PS_RUN    = 3'd0,
      PS_AHALT  = 3'd1,
      PS_SGRANT = 3'd2,
      PS_SNOOP  = 3'd3,
      PS_SLEEP  = 3'd4
   } pstate_e;

   // wake event bit positions
   localparam int EV_INIT  = 0;
   localparam int EV_BINIT = 1;
   localparam int EV_INTR  = 2;
   localparam int EV_NMI   = 3;
   localparam int EV_SMI   = 4;
   localparam int EV_NUM   = 5;

endpackage

// File: rtl/pwr_stopclk_exit_timer.sv
module pwr_stopclk_exit_timer #(
   parameter int EXIT_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = $clog2(EXIT_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(EXIT_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      if (EXIT_CYCLES < 1) $fatal(1, "EXIT_CYCLES must be at least 1");
   end

   assign expire_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!run_i || expire_o) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R5
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt_q == '0); // R5

endmodule

// File: rtl/pwr_stopclk_pend.sv
module pwr_stopclk_pend #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic         clr_i,
   input  logic [N-1:0] ev_i,
   output logic [N-1:0] pend_o
);
   initial begin
      if (N < 1) $fatal(1, "N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 flag_q <= 1'b0;
         else if (cap_i && ev_i[i])  flag_q <= 1'b1;
         else if (clr_i)             flag_q <= 1'b0;
      end

      assign pend_o[i] = flag_q;

      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q && !clr_i) |=> flag_q); // R6
   end

endmodule

// File: rtl/pwr_stopclk_fsm.sv
module pwr_stopclk_fsm
   import pwr_stopclk_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    stpclk_n,
   input  logic    slp_n,
   input  logic    halt_i,
   input  logic    snp_start_i,
   input  logic    snp_done_i,
   input  logic    wake_any_i,
   input  logic    rst_evt_i,
   input  logic    exit_done_i,
   output pstate_e state_o,
   output logic    exit_run_o,
   output logic    stopgnt_o,
   output logic    halt_cyc_o,
   output logic    reinit_o
);
   pstate_e state_q, nxt_state;
   pstate_e ret_q, nxt_ret;
   logic    stopgnt_q, halt_q, reinit_q;

   always_comb begin
      nxt_state = state_q;
      nxt_ret   = ret_q;
      unique case (state_q)
         PS_RUN: begin
            if (!stpclk_n)   nxt_state = PS_SGRANT;
            else if (halt_i) nxt_state = PS_AHALT;
         end
         PS_AHALT: begin
            if (!stpclk_n)                     nxt_state = PS_SGRANT;
            else if (wake_any_i || rst_evt_i)  nxt_state = PS_RUN;
            else if (snp_start_i) begin
               nxt_state = PS_SNOOP;
               nxt_ret   = PS_AHALT;
            end
         end
         PS_SGRANT: begin
            if (!stpclk_n && !slp_n) nxt_state = PS_SLEEP;
            else if (snp_start_i) begin
               nxt_state = PS_SNOOP;
               nxt_ret   = PS_SGRANT;
            end
            else if (exit_done_i)    nxt_state = PS_RUN;
         end
         PS_SNOOP: begin
            if (snp_done_i) nxt_state = ret_q;
         end
         PS_SLEEP: begin
            if (slp_n) nxt_state = PS_SGRANT;
         end
         default: nxt_state = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PS_RUN;
         ret_q     <= PS_SGRANT;
         stopgnt_q <= 1'b0;
         halt_q    <= 1'b0;
         reinit_q  <= 1'b0;
      end else begin
         state_q   <= nxt_state;
         ret_q     <= nxt_ret;
         stopgnt_q <= !stpclk_n && (state_q == PS_RUN || state_q == PS_AHALT);
         halt_q    <= stpclk_n && halt_i && (state_q == PS_RUN);
         reinit_q  <= rst_evt_i && (state_q == PS_RUN || state_q == PS_AHALT ||
                                    state_q == PS_SGRANT);
      end
   end

   assign state_o    = state_q;
   assign exit_run_o = (state_q == PS_SGRANT) && stpclk_n;
   assign stopgnt_o  = stopgnt_q;
   assign halt_cyc_o = halt_q;
   assign reinit_o   = reinit_q;

   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SLEEP) |-> ($past(state_q) == PS_SGRANT || $past(state_q) == PS_SLEEP)); // R10
   AST_SNOOP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SNOOP && snp_done_i) |=> (state_q == $past(ret_q))); // R9
   AST_SG_STAYS_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SGRANT && rst_evt_i && !stpclk_n && slp_n && !snp_start_i)
         |=> (state_q == PS_SGRANT && reinit_q)); // R8

endmodule

// File: rtl/pwr_stopclk_ctrl.sv
module pwr_stopclk_ctrl
   import pwr_stopclk_pkg::*;
#(
   parameter int EXIT_CYCLES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stpclk_n,
   input  logic              slp_n,
   input  logic              halt_i,
   input  logic              snp_start_i,
   input  logic              snp_done_i,
   input  logic [EV_NUM-1:0] wake_ev_i,
   input  logic              rst_ev_i,
   input  logic              pend_ack_i,
   output logic              stopgnt_req_o,
   output logic              halt_cyc_o,
   output logic              core_run_o,
   output logic              snoop_en_o,
   output logic              reinit_o,
   output logic [EV_NUM-1:0] pend_o
);
   localparam int CW = $clog2(EXIT_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(EXIT_CYCLES - 1);

   pstate_e state;
   logic    exit_run, exit_done;

   pwr_stopclk_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .stpclk_n    (stpclk_n),
      .slp_n       (slp_n),
      .halt_i      (halt_i),
      .snp_start_i (snp_start_i),
      .snp_done_i  (snp_done_i),
      .wake_any_i  (|wake_ev_i),
      .rst_evt_i   (rst_ev_i),
      .exit_done_i (exit_done),
      .state_o     (state),
      .exit_run_o  (exit_run),
      .stopgnt_o   (stopgnt_req_o),
      .halt_cyc_o  (halt_cyc_o),
      .reinit_o    (reinit_o)
   );

   pwr_stopclk_exit_timer #(.EXIT_CYCLES(EXIT_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (exit_run),
      .expire_o (exit_done)
   );

   pwr_stopclk_pend #(.N(EV_NUM)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (state == PS_SGRANT),
      .clr_i  (pend_ack_i && state == PS_RUN),
      .ev_i   (wake_ev_i),
      .pend_o (pend_o)
   );

   assign core_run_o = (state == PS_RUN);
   assign snoop_en_o = (state == PS_AHALT) || (state == PS_SGRANT) || (state == PS_SNOOP);

   // checker: consecutive released cycles seen in stop-grant
   logic [CW-1:0] rel_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               rel_q <= '0;
      else if (state == PS_SGRANT && stpclk_n)  rel_q <= rel_q + 1'b1;
      else                                      rel_q <= '0;
   end

   AST_EXIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_SGRANT) ##1 (state == PS_RUN) |-> ($past(rel_q) == LAST)); // R5
   AST_STOPGNT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      stopgnt_req_o |=> !stopgnt_req_o); // R4
   AST_HALT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_cyc_o |-> (!core_run_o && snoop_en_o)); // R2
   AST_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      core_run_o |-> !snoop_en_o); // R1
   AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_run_o && !(state == PS_SGRANT)) |=> (pend_o == $past(pend_o))); // R11

endmodule

// File: tb/pwr_stopclk_ctrl_tb.sv
module pwr_stopclk_ctrl_tb;
   localparam int EXIT_CYCLES = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       stpclk_n, slp_n, halt_i, snp_start_i, snp_done_i, rst_ev_i, pend_ack_i;
   logic [4:0] wake_ev_i;
   logic       stopgnt_req_o, halt_cyc_o, core_run_o, snoop_en_o, reinit_o;
   logic [4:0] pend_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pwr_stopclk_ctrl #(.EXIT_CYCLES(EXIT_CYCLES)) u_dut (
      .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
      .halt_i(halt_i), .snp_start_i(snp_start_i), .snp_done_i(snp_done_i),
      .wake_ev_i(wake_ev_i), .rst_ev_i(rst_ev_i), .pend_ack_i(pend_ack_i),
      .stopgnt_req_o(stopgnt_req_o), .halt_cyc_o(halt_cyc_o),
      .core_run_o(core_run_o), .snoop_en_o(snoop_en_o), .reinit_o(reinit_o),
      .pend_o(pend_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // behavioural reference model: 0 run, 1 auto-halt, 2 stop-grant, 3 snoop, 4 sleep
   int         ms, mret, mcnt, ns;
   bit         m_sg, m_hc, m_ri;
   logic [4:0] mp;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mret = 2; mcnt = 0; m_sg = 0; m_hc = 0; m_ri = 0; mp = '0;
      end else begin
         ns   = ms;
         m_sg = 0; m_hc = 0;
         m_ri = rst_ev_i && (ms <= 2);
         case (ms)
            0: if (!stpclk_n) begin ns = 2; m_sg = 1; end
               else if (halt_i) begin ns = 1; m_hc = 1; end
            1: if (!stpclk_n) begin ns = 2; m_sg = 1; end
               else if (wake_ev_i != 0 || rst_ev_i) ns = 0;
               else if (snp_start_i) begin ns = 3; mret = 1; end
            2: if (!stpclk_n && !slp_n) ns = 4;
               else if (snp_start_i) begin ns = 3; mret = 2; end
               else if (stpclk_n && mcnt == EXIT_CYCLES - 1) ns = 0;
            3: if (snp_done_i) ns = mret;
            default: if (slp_n) ns = 2;
         endcase
         if (ms == 2) mp = mp | wake_ev_i;
         else if (ms == 0 && pend_ack_i) mp = '0;
         mcnt = (ms == 2 && ns == 2 && stpclk_n) ? mcnt + 1 : 0;
         ms   = ns;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(core_run_o == (ms == 0) && snoop_en_o == (ms >= 1 && ms <= 3) &&
             stopgnt_req_o == m_sg && halt_cyc_o == m_hc && reinit_o == m_ri &&
             pend_o == mp, "MODEL", ms, int'(core_run_o));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      rst_n = 0; stpclk_n = 1; slp_n = 1; halt_i = 0; snp_start_i = 0;
      snp_done_i = 0; wake_ev_i = '0; rst_ev_i = 0; pend_ack_i = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();
      chk(core_run_o == 1, "R1", core_run_o, 1);
      chk(snoop_en_o == 0, "R1", snoop_en_o, 0);
      chk(pend_o == 0, "R1", pend_o, 0);

      // R2 halt
      halt_i = 1; step(); halt_i = 0;
      chk(halt_cyc_o == 1, "R2", halt_cyc_o, 1);
      chk(core_run_o == 0 && snoop_en_o == 1, "R2", core_run_o, 0);
      step();
      chk(halt_cyc_o == 0, "R2", halt_cyc_o, 0);

      // R3 INTR wake
      wake_ev_i = 5'b00100; step(); wake_ev_i = '0;
      chk(core_run_o == 1, "R3", core_run_o, 1);
      // R3 / R8 reset event wakes auto-halt
      halt_i = 1; step(); halt_i = 0;
      rst_ev_i = 1; step(); rst_ev_i = 0;
      chk(core_run_o == 1, "R3", core_run_o, 1);
      chk(reinit_o == 1, "R8", reinit_o, 1);

      // R12 stop-clock beats halt, R4 single pulse
      halt_i = 1; stpclk_n = 0; step(); halt_i = 0;
      chk(stopgnt_req_o == 1 && halt_cyc_o == 0, "R12", stopgnt_req_o, 1);
      step();
      chk(stopgnt_req_o == 0, "R4", stopgnt_req_o, 0);
      step();
      chk(stopgnt_req_o == 0 && core_run_o == 0, "R4", stopgnt_req_o, 0);

      // R6 / R7 latching in stop-grant
      wake_ev_i = 5'b00110; step(); wake_ev_i = '0;
      chk(core_run_o == 0, "R7", core_run_o, 0);
      chk(pend_o == 5'b00110, "R6", pend_o, 6);

      // R8 reset in stop-grant
      rst_ev_i = 1; step(); rst_ev_i = 0;
      chk(reinit_o == 1 && core_run_o == 0 && snoop_en_o == 1, "R8", reinit_o, 1);
      step();
      chk(reinit_o == 0, "R8", reinit_o, 0);

      // R9 snoop from stop-grant
      snp_start_i = 1; step(); snp_start_i = 0;
      chk(snoop_en_o == 1 && core_run_o == 0, "R9", snoop_en_o, 1);
      step();
      snp_done_i = 1; step(); snp_done_i = 0;

      // R10 sleep (only reachable from stop-grant)
      slp_n = 0; step();
      chk(snoop_en_o == 0, "R10", snoop_en_o, 0);
      snp_start_i = 1; wake_ev_i = 5'b01000; step(); snp_start_i = 0; wake_ev_i = '0;
      chk(pend_o == 5'b00110 && snoop_en_o == 0, "R10", pend_o, 6);
      slp_n = 1; step();
      chk(snoop_en_o == 1 && core_run_o == 0, "R10", snoop_en_o, 1);

      // R11 ack ignored outside run
      pend_ack_i = 1; step(); pend_ack_i = 0;
      chk(pend_o == 5'b00110, "R11", pend_o, 6);

      // R5 restart then full exit count
      stpclk_n = 1; repeat (4) step();
      chk(core_run_o == 0, "R5", core_run_o, 0);
      stpclk_n = 0; step();
      stpclk_n = 1;
      n = 0;
      for (int k = 0; k < 40 && !core_run_o; k++) begin step(); n++; end
      chk(n == EXIT_CYCLES, "R5", n, EXIT_CYCLES);
      chk(pend_o == 5'b00110, "R6", pend_o, 6);
      pend_ack_i = 1; step(); pend_ack_i = 0;
      chk(pend_o == 0, "R11", pend_o, 0);

      // R9 snoop from auto-halt returns to auto-halt
      halt_i = 1; step(); halt_i = 0;
      snp_start_i = 1; step(); snp_start_i = 0;
      snp_done_i = 1; step(); snp_done_i = 0;
      wake_ev_i = 5'b10000; step(); wake_ev_i = '0;
      chk(core_run_o == 1 && pend_o == 0, "R9", core_run_o, 1);

      // R12 stop-clock beats snoop and wake in auto-halt
      halt_i = 1; step(); halt_i = 0;
      stpclk_n = 0; snp_start_i = 1; wake_ev_i = 5'b00001; step();
      snp_start_i = 0; wake_ev_i = '0;
      chk(stopgnt_req_o == 1 && core_run_o == 0, "R12", stopgnt_req_o, 1);
      stpclk_n = 1;
      n = 0;
      for (int k = 0; k < 40 && !core_run_o; k++) begin step(); n++; end
      chk(n == EXIT_CYCLES, "R12", n, EXIT_CYCLES);

      step();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule